// File: doc/BRIEF.md
# Segment Descriptor Cache Loader

This block holds the visible selector and the hidden cached fields (base, limit, attributes) of a set of segment registers. A write to one segment register selects one of two behaviours through the protection-enable input. With protection off, the selector is stored and the cached base becomes selector × 16, with no memory traffic. With protection on, the selector picks a descriptor table and an 8-byte entry. The block checks that the entry lies inside the table's 16-bit limit, reads the entry as two 32-bit words and checks that the segment is present. Only then does it load the unpacked base, limit and attributes into the cache.

A table register pair (linear base and 16-bit limit) is supplied for the global table and one for the local table. Memory is reached through a request/valid read port whose response may stall for any number of cycles. The block stays busy from an accepted protected write until the entry is committed or rejected. A rejected write raises a one-cycle fault pulse and leaves the segment unchanged.

Top module: `seg_cache_loader`

## Requirements
- R1: After reset every selector, base, limit and attribute output is zero, and `busy_o`, `fault_o` and `mem_req_o` are low.
- R2: A write accepted with `pe_i` low stores the selector and sets that segment's base to selector × 16 on the next clock edge. Limit and attributes are unchanged, no memory request is issued and `busy_o` stays low.
- R3: A write accepted with `pe_i` high issues two reads, first at table base + (selector & 0xFFF8) and then at that address + 4. `mem_addr_o` is held while a request waits for `mem_valid_i`. `busy_o` is high from the edge after the write until the edge that takes the second word.
- R4: Selector bit 2 chooses the table: 0 selects the global table, 1 the local table.
- R5: Words are little-endian. Word 0 holds limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. Word 1 holds base[23:16] in bits 7:0, the access byte in bits 15:8, limit[19:16] in bits 19:16, the flags in bits 23:20 and base[31:24] in bits 31:24. `attr_o` per segment is {flags, access}, which places D at bit 10 and G at bit 11.
- R6: When flag G is 1, the cached limit is {limit[19:0], 12'hFFF}; otherwise it is limit[19:0] zero-extended.
- R7: If (selector & 0xFFF8) + 7 exceeds the chosen table's limit, no request is made, `fault_o` is high for the cycle after the write, and the segment, including its selector, keeps its old contents. An entry ending exactly at the limit is accepted.
- R8: If access byte bit 7 (present) is 0, nothing is loaded and `fault_o` pulses in the cycle after the second word is taken.
- R9: Writes presented while `busy_o` is high are ignored.
- R10: Changing `pe_i` alone alters no cached output. The selector and the base it produced stay in place until the next write.
- R11: A write changes only the segment named by `wr_seg_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Segment register write strobe |
| wr_seg_i | input | SEG_W (3) | Segment index to write |
| wr_sel_i | input | 16 | Selector value written |
| pe_i | input | 1 | Protection enable |
| gdt_base_i | input | 32 | Global table linear base |
| gdt_limit_i | input | 16 | Global table limit |
| ldt_base_i | input | 32 | Local table linear base |
| ldt_limit_i | input | 16 | Local table limit |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read address |
| mem_valid_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Descriptor fetch in progress |
| fault_o | output | 1 | One-cycle reject pulse |
| sel_o | output | NUM_SEG*16 | Visible selectors, segment n at bits n*16 +: 16 |
| base_o | output | NUM_SEG*32 | Cached bases |
| limit_o | output | NUM_SEG*32 | Cached effective limits |
| attr_o | output | NUM_SEG*12 | Cached {flags, access} |

## Verification
A stuck or skipped fetch state shows as a wrong read address or as `busy_o` failing to drop after the second valid word. The bench sees this within a few cycles of each protected write. A bad bounds or present decision shows in the cycle after the deciding edge, as a missing or spurious fault pulse or a segment loaded when it should not be. Errors in the field unpacking or the limit scaling appear on the cached outputs as soon as `busy_o` falls. A write strobe routed to the wrong segment shows as a change in a segment that the bench expects to keep its values.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef struct packed {
    logic [31:0] base;
    logic [31:0] limit;
    logic [11:0] attr;
  } seg_desc_t;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} fetch_st_e;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen (
  input  logic [15:0] sel_i,
  input  logic [31:0] gdt_base_i,
  input  logic [15:0] gdt_limit_i,
  input  logic [31:0] ldt_base_i,
  input  logic [15:0] ldt_limit_i,
  output logic [31:0] addr_o,
  output logic        in_bounds_o
);
  logic [15:0] offset;
  logic [31:0] tbl_base;
  logic [15:0] tbl_limit;
  logic [16:0] last_byte;

  always_comb begin
    offset    = {sel_i[15:3], 3'b000};
    tbl_base  = sel_i[2] ? ldt_base_i  : gdt_base_i;
    tbl_limit = sel_i[2] ? ldt_limit_i : gdt_limit_i;
    last_byte = {1'b0, offset} + 17'd7;
    addr_o    = tbl_base + {16'h0, offset};
    in_bounds_o = (last_byte <= {1'b0, tbl_limit});
  end
endmodule

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_pkg::*;
(
  input  logic [31:0] lo_i,
  input  logic [31:0] hi_i,
  output seg_desc_t   desc_o,
  output logic        present_o
);
  logic [19:0] raw_lim;
  logic [7:0]  access;
  logic [3:0]  flags;

  always_comb begin
    raw_lim = {hi_i[19:16], lo_i[15:0]};
    access  = hi_i[15:8];
    flags   = hi_i[23:20];
    desc_o.base  = {hi_i[31:24], hi_i[7:0], lo_i[31:16]};
    desc_o.limit = flags[3] ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
    desc_o.attr  = {flags, access};
    present_o    = access[7];
  end
endmodule

// File: rtl/seg_cache_regs.sv
module seg_cache_regs
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SEG-1:0]    rm_we_i,
  input  logic [15:0]           rm_sel_i,
  input  logic [NUM_SEG-1:0]    pm_we_i,
  input  logic [15:0]           pm_sel_i,
  input  seg_desc_t             pm_desc_i,
  output logic [NUM_SEG*16-1:0] sel_o,
  output logic [NUM_SEG*32-1:0] base_o,
  output logic [NUM_SEG*32-1:0] limit_o,
  output logic [NUM_SEG*12-1:0] attr_o
);
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [15:0] sel_q;
    logic [31:0] base_q, limit_q;
    logic [11:0] attr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q   <= '0;
        base_q  <= '0;
        limit_q <= '0;
        attr_q  <= '0;
      end else if (pm_we_i[g]) begin
        sel_q   <= pm_sel_i;
        base_q  <= pm_desc_i.base;
        limit_q <= pm_desc_i.limit;
        attr_q  <= pm_desc_i.attr;
      end else if (rm_we_i[g]) begin
        sel_q  <= rm_sel_i;
        base_q <= {12'h000, rm_sel_i, 4'h0};
      end
    end

    assign sel_o[g*16 +: 16]   = sel_q;
    assign base_o[g*32 +: 32]  = base_q;
    assign limit_o[g*32 +: 32] = limit_q;
    assign attr_o[g*12 +: 12]  = attr_q;
  end

  // R11: at most one segment written per cycle
  a_r11_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rm_we_i | pm_we_i) && !((|rm_we_i) && (|pm_we_i)));
endmodule

// File: rtl/seg_cache_loader.sv
module seg_cache_loader
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 6,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [SEG_W-1:0]      wr_seg_i,
  input  logic [15:0]           wr_sel_i,
  input  logic                  pe_i,
  input  logic [31:0]           gdt_base_i,
  input  logic [15:0]           gdt_limit_i,
  input  logic [31:0]           ldt_base_i,
  input  logic [15:0]           ldt_limit_i,
  output logic                  mem_req_o,
  output logic [31:0]           mem_addr_o,
  input  logic                  mem_valid_i,
  input  logic [31:0]           mem_rdata_i,
  output logic                  busy_o,
  output logic                  fault_o,
  output logic [NUM_SEG*16-1:0] sel_o,
  output logic [NUM_SEG*32-1:0] base_o,
  output logic [NUM_SEG*32-1:0] limit_o,
  output logic [NUM_SEG*12-1:0] attr_o
);
  fetch_st_e        st_q;
  logic [SEG_W-1:0] pend_seg_q;
  logic [15:0]      pend_sel_q;
  logic [31:0]      addr_q, lo_q;
  logic             fault_q;

  logic [31:0]      desc_addr;
  logic             in_bounds, present, accept;
  seg_desc_t        desc;
  logic [NUM_SEG-1:0] rm_we, pm_we;

  seg_addr_gen u_addr (
    .sel_i       (wr_sel_i),
    .gdt_base_i  (gdt_base_i),
    .gdt_limit_i (gdt_limit_i),
    .ldt_base_i  (ldt_base_i),
    .ldt_limit_i (ldt_limit_i),
    .addr_o      (desc_addr),
    .in_bounds_o (in_bounds)
  );

  seg_desc_decode u_dec (
    .lo_i      (lo_q),
    .hi_i      (mem_rdata_i),
    .desc_o    (desc),
    .present_o (present)
  );

  assign accept = wr_en_i && (st_q == S_IDLE);

  always_comb begin
    rm_we = '0;
    pm_we = '0;
    if (accept && !pe_i)
      rm_we[wr_seg_i] = 1'b1;
    if (st_q == S_HI && mem_valid_i && present)
      pm_we[pend_seg_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      pend_seg_q <= '0;
      pend_sel_q <= '0;
      addr_q     <= '0;
      lo_q       <= '0;
      fault_q    <= 1'b0;
    end else begin
      fault_q <= 1'b0;
      case (st_q)
        S_IDLE: if (accept && pe_i) begin
          if (in_bounds) begin
            st_q       <= S_LO;
            addr_q     <= desc_addr;
            pend_seg_q <= wr_seg_i;
            pend_sel_q <= wr_sel_i;
          end else begin
            fault_q <= 1'b1;
          end
        end
        S_LO: if (mem_valid_i) begin
          lo_q <= mem_rdata_i;
          st_q <= S_HI;
        end
        S_HI: if (mem_valid_i) begin
          st_q    <= S_IDLE;
          fault_q <= !present;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q != S_IDLE);
  assign mem_addr_o = (st_q == S_HI) ? addr_q + 32'd4 : addr_q;
  assign busy_o     = (st_q != S_IDLE);
  assign fault_o    = fault_q;

  seg_cache_regs #(.NUM_SEG(NUM_SEG)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rm_we_i   (rm_we),
    .rm_sel_i  (wr_sel_i),
    .pm_we_i   (pm_we),
    .pm_sel_i  (pend_sel_q),
    .pm_desc_i (desc),
    .sel_o     (sel_o),
    .base_o    (base_o),
    .limit_o   (limit_o),
    .attr_o    (attr_o)
  );

  // R3: a request only while busy, address held while stalled
  a_r3_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  a_r3_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R2: real-mode write never starts a fetch
  a_r2_rm_nofetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !busy_o && !pe_i) |=> !busy_o);
  // R7/R8: a fault ends any activity
  a_r7_fault_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!busy_o && !mem_req_o));
endmodule

// File: tb/seg_cache_loader_test.sv
module seg_cache_loader_test;
  localparam int NUM_SEG = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_seg = '0;
  logic [15:0] wr_sel = '0;
  logic        pe = 1'b0;
  logic        mem_req, mem_valid, busy, fault;
  logic [31:0] mem_addr, mem_rdata;
  logic [NUM_SEG*16-1:0] sel_v;
  logic [NUM_SEG*32-1:0] base_v, limit_v;
  logic [NUM_SEG*12-1:0] attr_v;

  logic [31:0] mem [256];
  int          lat = 0;
  int          stall = 0;
  logic [31:0] alog [64];
  int          nlog = 0;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  seg_cache_loader #(.NUM_SEG(NUM_SEG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_seg_i(wr_seg),
    .wr_sel_i(wr_sel), .pe_i(pe),
    .gdt_base_i(32'h0000_0000), .gdt_limit_i(16'h003F),
    .ldt_base_i(32'h0000_0200), .ldt_limit_i(16'h001F),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .fault_o(fault),
    .sel_o(sel_v), .base_o(base_v), .limit_o(limit_v), .attr_o(attr_v)
  );

  assign mem_valid = mem_req && (stall >= lat);
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && !mem_valid) stall <= stall + 1;
    else stall <= 0;
    if (mem_req && mem_valid) begin
      alog[nlog[5:0]] <= mem_addr;
      nlog <= nlog + 1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_seg(input string req, input int s, input logic [15:0] sel,
                         input logic [31:0] b, input logic [31:0] l, input logic [11:0] a);
    chk({req, " sel"},   {16'h0, sel_v[s*16 +: 16]}, {16'h0, sel});
    chk({req, " base"},  base_v[s*32 +: 32], b);
    chk({req, " limit"}, limit_v[s*32 +: 32], l);
    chk({req, " attr"},  {20'h0, attr_v[s*12 +: 12]}, {20'h0, a});
  endtask

  task automatic put_desc(input int addr, input logic [31:0] b, input logic [19:0] l,
                          input logic [7:0] acc, input logic [3:0] fl);
    mem[addr >> 2]       = {b[15:0], l[15:0]};
    mem[(addr >> 2) + 1] = {b[31:24], fl, l[19:16], acc, b[23:16]};
  endtask

  // drive one write strobe; returns at the negedge after the accepting edge
  task automatic do_write(input int s, input logic [15:0] sel);
    @(negedge clk);
    wr_en = 1'b1; wr_seg = 3'(s); wr_sel = sel;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output logic flt);
    int n = 0;
    while (busy && n < 100) begin @(negedge clk); n++; end
    flt = fault;
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'h0, busy}, 32'h0);
    chk("R1 fault", {31'h0, fault}, 32'h0);
    chk("R1 req", {31'h0, mem_req}, 32'h0);
    for (int s = 0; s < NUM_SEG; s++) chk_seg("R1", s, 16'h0, 32'h0, 32'h0, 12'h0);
  endtask

  task automatic t_real_mode();
    int n0 = nlog;
    pe = 1'b0;
    do_write(0, 16'h1234);
    chk("R2 busy", {31'h0, busy}, 32'h0);
    chk_seg("R2", 0, 16'h1234, 32'h0001_2340, 32'h0, 12'h0);
    chk_seg("R11 rm", 1, 16'h0, 32'h0, 32'h0, 12'h0);
    @(negedge clk);
    chk("R2 no fetch", nlog - n0, 0);
  endtask

  task automatic t_pm_gdt();
    int n0 = nlog; logic f;
    pe = 1'b1; lat = 0;
    put_desc(32'h10, 32'hA1B2_C3D4, 20'h5_6789, 8'h92, 4'h4);
    do_write(1, 16'h0013);
    chk("R3 busy", {31'h0, busy}, 32'h1);
    wait_idle(f);
    chk("R3 reads", nlog - n0, 2);
    chk("R3 addr0 R4 gdt", alog[n0[5:0]], 32'h10);
    chk("R3 addr1", alog[(n0 + 1) & 63], 32'h14);
    chk("R5 no fault", {31'h0, f}, 32'h0);
    chk_seg("R5", 1, 16'h0013, 32'hA1B2_C3D4, 32'h0005_6789, 12'h492);
    chk_seg("R11 pm", 0, 16'h1234, 32'h0001_2340, 32'h0, 12'h0);
  endtask

  task automatic t_pm_ldt_gran();
    int n0 = nlog; logic f;
    lat = 2;
    put_desc(32'h208, 32'h0010_0000, 20'h0_00FF, 8'h9A, 4'hC);
    do_write(2, 16'h000C);
    wait_idle(f);
    chk("R4 ldt addr0", alog[n0[5:0]], 32'h208);
    chk("R4 ldt addr1", alog[(n0 + 1) & 63], 32'h20C);
    chk_seg("R6", 2, 16'h000C, 32'h0010_0000, 32'h000F_FFFF, 12'hC9A);
    lat = 0;
  endtask

  task automatic t_bounds();
    int n0 = nlog; logic f;
    do_write(3, 16'h0040);
    chk("R7 fault gdt", {31'h0, fault}, 32'h1);
    chk("R7 busy", {31'h0, busy}, 32'h0);
    @(negedge clk);
    chk("R7 pulse end", {31'h0, fault}, 32'h0);
    chk("R7 no req", nlog - n0, 0);
    chk_seg("R7", 3, 16'h0, 32'h0, 32'h0, 12'h0);
    do_write(3, 16'h0024);
    chk("R7 fault ldt", {31'h0, fault}, 32'h1);
    put_desc(32'h218, 32'h0000_5000, 20'h0_0FFF, 8'h93, 4'h0);
    do_write(3, 16'h001C);
    chk("R7 edge accepted", {31'h0, busy}, 32'h1);
    wait_idle(f);
    chk("R7 edge no fault", {31'h0, f}, 32'h0);
    chk_seg("R7 edge", 3, 16'h001C, 32'h0000_5000, 32'h0000_0FFF, 12'h093);
  endtask

  task automatic t_not_present();
    logic f;
    put_desc(32'h18, 32'h1111_2222, 20'h3_3333, 8'h12, 4'h0);
    do_write(4, 16'h0018);
    wait_idle(f);
    chk("R8 fault", {31'h0, f}, 32'h1);
    @(negedge clk);
    chk("R8 pulse end", {31'h0, fault}, 32'h0);
    chk_seg("R8", 4, 16'h0, 32'h0, 32'h0, 12'h0);
  endtask

  task automatic t_busy_ignore();
    logic f;
    lat = 3;
    do_write(5, 16'h0010);
    @(negedge clk);
    wr_en = 1'b1; wr_seg = 3'd0; wr_sel = 16'h5555;
    @(negedge clk);
    wr_en = 1'b0;
    wait_idle(f);
    chk_seg("R9 ignored", 0, 16'h1234, 32'h0001_2340, 32'h0, 12'h0);
    chk_seg("R9 loaded", 5, 16'h0010, 32'hA1B2_C3D4, 32'h0005_6789, 12'h492);
    lat = 0;
  endtask

  task automatic t_pe_drop();
    @(negedge clk);
    pe = 1'b0;
    repeat (3) @(negedge clk);
    chk_seg("R10 kept", 1, 16'h0013, 32'hA1B2_C3D4, 32'h0005_6789, 12'h492);
    do_write(1, 16'h0020);
    chk_seg("R10 R2 rm", 1, 16'h0020, 32'h0000_0200, 32'h0005_6789, 12'h492);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_real_mode();
    t_pm_gdt();
    t_pm_ldt_gran();
    t_bounds();
    t_not_present();
    t_busy_ignore();
    t_pe_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule